// File: doc/BRIEF.md
# Prioritized Level Interrupt Controller

This block gathers level-sensitive interrupt lines, grouped in banks of 32, and presents one request line to the processor. Software controls it through a small memory-mapped register port: address, write data, write enable and combinational read data. Each source can be masked. It carries a 6-bit priority, where lower values win. A global threshold can hold back sources whose priority is not urgent enough.

When no interrupt is being serviced and an eligible source exists, the controller latches the winning source number and raises its request output. The number stays frozen until software writes the acknowledge bit. A new arbitration then runs on the next cycle. The acknowledge also removes a latched interrupt whose line was masked or dropped while it was being serviced. A soft reset, started from a configuration bit, returns every register to its reset value after a fixed number of cycles and reports completion in a status bit.

The number of banks is a parameter: three banks give 96 sources, and four banks give 128. Every configuration register can be read back, so software can save and restore the block's context.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After rst_n is low, and after a soft reset completes, the block is in this state. Every mask bit is 1. All priorities are 0, and so are the threshold, idle, protection and configuration bit 0. The latched number reads 0 and irq_out is 0. Status bit 0 at 0x14 reads 1 whenever no soft reset is running.
- R2: Bank n has a mask register at 0x84+0x20*n that reads and writes as a whole. A write to 0x88+0x20*n clears the mask bits where the data holds a one, which enables those sources. A write to 0x8C+0x20*n sets the mask bits where the data holds a one. All other bits keep their value.
- R3: The read-only register at 0x98+0x20*n returns each source line of bank n ANDed with the inverse of its mask bit. Source bit k of bank n is source number 32*n+k.
- R4: A source is eligible when its line is high and its mask bit is 0, and one of two conditions holds: its priority (bits 7:2 of its level register) is strictly below the threshold (0x68, bits 7:0), or the threshold is 0xFF. Among eligible sources the lowest priority value wins, and ties go to the lowest source number. A threshold of 0 blocks every source.
- R5: When nothing is latched and a winner exists, at the next clock edge irq_out goes to 1 and bits 6:0 of 0x40 report the winner's number. Both hold, even if a more urgent source appears, until an acknowledge.
- R6: Writing a 1 in bit 0 of 0x48 clears the latch. irq_out then reads 0 and 0x40 reads 0 for at least one cycle, and arbitration resumes at the following edge. Writing 0 to 0x48 has no effect.
- R7: A latched interrupt whose source is masked or deasserted stays latched, with irq_out at 1, until the acknowledge removes it.
- R8: Writing a 1 to bit 1 of 0x10 starts a soft reset. For the next SR_CYCLES cycles (default 4), bit 1 of 0x10 reads 1 and status bit 0 at 0x14 reads 0. Then the R1 state is restored and both bits return to the idle values.
- R9: The level register of source i at 0x100+4*i reads back its priority in bits 7:2. The threshold reads back in bits 7:0, the idle register at 0x50 in bits 1:0, protection at 0x4C in bit 0, and configuration bit 0 at 0x10. All unused bits read 0.
- R10: The read-only register at 0x00 returns the REV_MAJOR parameter in bits 7:4 and REV_MINOR in bits 3:0 (default 0x21).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NUM_BANKS*32 | Level interrupt lines, bit i is source i |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_out | output | 1 | Combined request to the processor |

## Verification
The arbitration is exercised with directed patterns. A single source checks the basic latch. A more urgent source arriving while another is latched shows that the number is frozen. Equal priorities separate a lowest-number tie-break from any other order. A source in the top bank confirms that bank indexing reaches the last bit, and threshold values on either side of a priority show a strict compare against an inclusive one. A random phase then mixes source toggles, set and clear alias writes, level and threshold writes and acknowledges, so that masking-while-active and deassert-while-active cases occur in many orders. Throughout, the pending registers and the latched number are compared against a bench model.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

   localparam int BANK_W    = 32;
   localparam int PRIO_W    = 6;
   localparam int NUM_W     = 7;
   localparam int THR_W     = 8;
   localparam int MAX_BANKS = 4;

   // register byte offsets
   localparam int unsigned OFS_REV    = 32'h000;
   localparam int unsigned OFS_CFG    = 32'h010;
   localparam int unsigned OFS_STAT   = 32'h014;
   localparam int unsigned OFS_SORTED = 32'h040;
   localparam int unsigned OFS_CTRL   = 32'h048;
   localparam int unsigned OFS_PROT   = 32'h04C;
   localparam int unsigned OFS_IDLE   = 32'h050;
   localparam int unsigned OFS_THR    = 32'h068;
   localparam int unsigned OFS_MASK0  = 32'h084;
   localparam int unsigned OFS_MCLR0  = 32'h088;
   localparam int unsigned OFS_MSET0  = 32'h08C;
   localparam int unsigned OFS_PEND0  = 32'h098;
   localparam int unsigned OFS_LVL0   = 32'h100;
   localparam int unsigned BANK_STEP  = 32'h020;
   localparam int unsigned LVL_STEP   = 4;

   typedef struct packed {
      logic             valid;
      logic [NUM_W-1:0] num;
   } win_t;

endpackage

// File: rtl/pic_mask_bank.sv
module pic_mask_bank #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_all,
   input  logic         we_whole,
   input  logic         we_clr,
   input  logic         we_set,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] src,
   output logic [W-1:0] mask_q,
   output logic [W-1:0] pend
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_q <= '1;
      else if (clear_all) mask_q <= '1;
      else if (we_whole)  mask_q <= wdata;
      else if (we_clr)    mask_q <= mask_q & ~wdata;
      else if (we_set)    mask_q <= mask_q | wdata;
   end

   assign pend = src & ~mask_q;

endmodule

// File: rtl/pic_level_file.sv
module pic_level_file #(
   parameter int N      = 96,
   parameter int PRIO_W = 6,
   parameter int IDX_W  = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear_all,
   input  logic                we,
   input  logic [IDX_W-1:0]    widx,
   input  logic [PRIO_W-1:0]   wprio,
   input  logic [IDX_W-1:0]    ridx,
   output logic [PRIO_W-1:0]   rprio,
   output logic [N*PRIO_W-1:0] prio_flat
);

   logic [PRIO_W-1:0] lvl_q [N];

   for (genvar i = 0; i < N; i++) begin : g_lvl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           lvl_q[i] <= '0;
         else if (clear_all)                   lvl_q[i] <= '0;
         else if (we && widx == IDX_W'(i))     lvl_q[i] <= wprio;
      end
      assign prio_flat[i*PRIO_W +: PRIO_W] = lvl_q[i];
   end

   always_comb begin
      rprio = '0;
      for (int i = 0; i < N; i++)
         if (ridx == IDX_W'(i)) rprio = lvl_q[i];
   end

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
   import prio_irq_pkg::*;
#(
   parameter int N = 96
) (
   input  logic [N-1:0]        cand,
   input  logic [N*PRIO_W-1:0] prio_flat,
   input  logic [THR_W-1:0]    thr,
   output win_t                win
);

   logic              best_v;
   logic [PRIO_W-1:0] best_p;
   logic [NUM_W-1:0]  best_n;
   logic [PRIO_W-1:0] p;
   logic              elig;

   // ascending scan with strict compare keeps the lowest index on ties
   always_comb begin
      best_v = 1'b0;
      best_p = '0;
      best_n = '0;
      p      = '0;
      elig   = 1'b0;
      for (int i = 0; i < N; i++) begin
         p    = prio_flat[i*PRIO_W +: PRIO_W];
         elig = cand[i] && ((thr == '1) || (THR_W'(p) < thr));
         if (elig && (!best_v || p < best_p)) begin
            best_v = 1'b1;
            best_p = p;
            best_n = NUM_W'(i);
         end
      end
      win.valid = best_v;
      win.num   = best_n;
   end

endmodule

// File: rtl/pic_soft_reset.sv
module pic_soft_reset #(
   parameter int CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic clear_all
);

   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] cnt_q;

   assign clear_all = busy && (cnt_q == CW'(CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (clear_all) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (busy) begin
         cnt_q <= cnt_q + 1'b1;
      end else if (start) begin
         busy  <= 1'b1;
         cnt_q <= '0;
      end
   end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int NUM_BANKS = 3,
   parameter int ADDR_W    = 10,
   parameter int REV_MAJOR = 2,
   parameter int REV_MINOR = 1,
   parameter int SR_CYCLES = 4,
   localparam int NUM_SRC  = NUM_BANKS * BANK_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_src,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [31:0]        reg_wdata,
   input  logic               reg_we,
   output logic [31:0]        reg_rdata,
   output logic               irq_out
);

   localparam int IDX_W   = $clog2(NUM_SRC);
   localparam int LVL_END = OFS_LVL0 + LVL_STEP * NUM_SRC;

   // elaboration-time parameter checks
   if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must lie in 1..%0d", MAX_BANKS);
   end
   if (LVL_END >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the level registers");
   end
   if (SR_CYCLES < 1) begin : g_bad_sr
      $error("SR_CYCLES must be at least 1");
   end
   if (REV_MAJOR > 15 || REV_MINOR > 15 || REV_MAJOR < 0 || REV_MINOR < 0) begin : g_bad_rev
      $error("revision fields are 4 bits each");
   end
   if (NUM_SRC > (1 << NUM_W)) begin : g_bad_num
      $error("source count exceeds the sorted number width");
   end

   logic                  ack_wr, sr_start, sr_busy, clear_all;
   logic                  cfg_auto_q, prot_q;
   logic [1:0]            idle_q;
   logic [THR_W-1:0]      thr_q;
   logic [NUM_SRC-1:0]    mask_vec, pend_vec;
   logic                  act_v;
   logic [NUM_W-1:0]      act_num;
   win_t                  win;
   logic                  win_valid;
   logic [NUM_W-1:0]      win_num;
   logic [NUM_SRC*PRIO_W-1:0] prio_flat;
   logic                  lvl_hit;
   logic [ADDR_W-1:0]     lvl_off;
   logic [IDX_W-1:0]      lvl_idx;
   logic [PRIO_W-1:0]     lvl_rd;

   assign ack_wr   = reg_we && (reg_addr == ADDR_W'(OFS_CTRL)) && reg_wdata[0];
   assign sr_start = reg_we && (reg_addr == ADDR_W'(OFS_CFG)) && reg_wdata[1];

   // ---------------- mask banks ----------------
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit_whole, hit_clr, hit_set;
      assign hit_whole = reg_we && (reg_addr == ADDR_W'(OFS_MASK0 + BANK_STEP * b));
      assign hit_clr   = reg_we && (reg_addr == ADDR_W'(OFS_MCLR0 + BANK_STEP * b));
      assign hit_set   = reg_we && (reg_addr == ADDR_W'(OFS_MSET0 + BANK_STEP * b));

      pic_mask_bank #(.W(BANK_W)) i_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .clear_all (clear_all),
         .we_whole  (hit_whole),
         .we_clr    (hit_clr),
         .we_set    (hit_set),
         .wdata     (reg_wdata),
         .src       (irq_src[b*BANK_W +: BANK_W]),
         .mask_q    (mask_vec[b*BANK_W +: BANK_W]),
         .pend      (pend_vec[b*BANK_W +: BANK_W])
      );
   end

   // ---------------- per-source levels ----------------
   assign lvl_off = reg_addr - ADDR_W'(OFS_LVL0);
   assign lvl_idx = IDX_W'(lvl_off >> 2);
   assign lvl_hit = (reg_addr >= ADDR_W'(OFS_LVL0)) &&
                    (reg_addr <  ADDR_W'(LVL_END))   &&
                    (reg_addr[1:0] == 2'b00);

   pic_level_file #(.N(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) i_levels (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_all (clear_all),
      .we        (reg_we && lvl_hit),
      .widx      (lvl_idx),
      .wprio     (reg_wdata[PRIO_W+1:2]),
      .ridx      (lvl_idx),
      .rprio     (lvl_rd),
      .prio_flat (prio_flat)
   );

   // ---------------- arbitration ----------------
   pic_arbiter #(.N(NUM_SRC)) i_arb (
      .cand      (pend_vec),
      .prio_flat (prio_flat),
      .thr       (thr_q),
      .win       (win)
   );
   assign win_valid = win.valid;
   assign win_num   = win.num;

   // ---------------- soft reset ----------------
   pic_soft_reset #(.CYCLES(SR_CYCLES)) i_srst (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (sr_start),
      .busy      (sr_busy),
      .clear_all (clear_all)
   );

   // ---------------- control registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_auto_q <= 1'b0;
         prot_q     <= 1'b0;
         idle_q     <= '0;
         thr_q      <= '0;
      end else if (clear_all) begin
         cfg_auto_q <= 1'b0;
         prot_q     <= 1'b0;
         idle_q     <= '0;
         thr_q      <= '0;
      end else if (reg_we) begin
         if (reg_addr == ADDR_W'(OFS_CFG))  cfg_auto_q <= reg_wdata[0];
         if (reg_addr == ADDR_W'(OFS_PROT)) prot_q     <= reg_wdata[0];
         if (reg_addr == ADDR_W'(OFS_IDLE)) idle_q     <= reg_wdata[1:0];
         if (reg_addr == ADDR_W'(OFS_THR))  thr_q      <= reg_wdata[THR_W-1:0];
      end
   end

   // ---------------- active-source latch ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_v   <= 1'b0;
         act_num <= '0;
      end else if (clear_all || ack_wr) begin
         act_v   <= 1'b0;
         act_num <= '0;
      end else if (!act_v && win_valid) begin
         act_v   <= 1'b1;
         act_num <= win_num;
      end
   end

   assign irq_out = act_v;

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(OFS_REV))
         reg_rdata[7:0] = {4'(REV_MAJOR), 4'(REV_MINOR)};
      else if (reg_addr == ADDR_W'(OFS_CFG))
         reg_rdata[1:0] = {sr_busy, cfg_auto_q};
      else if (reg_addr == ADDR_W'(OFS_STAT))
         reg_rdata[0] = !sr_busy;
      else if (reg_addr == ADDR_W'(OFS_SORTED))
         reg_rdata[NUM_W-1:0] = act_num;
      else if (reg_addr == ADDR_W'(OFS_PROT))
         reg_rdata[0] = prot_q;
      else if (reg_addr == ADDR_W'(OFS_IDLE))
         reg_rdata[1:0] = idle_q;
      else if (reg_addr == ADDR_W'(OFS_THR))
         reg_rdata[THR_W-1:0] = thr_q;
      else if (lvl_hit)
         reg_rdata[PRIO_W+1:2] = lvl_rd;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (reg_addr == ADDR_W'(OFS_MASK0 + BANK_STEP * b))
            reg_rdata = mask_vec[b*BANK_W +: BANK_W];
         if (reg_addr == ADDR_W'(OFS_PEND0 + BANK_STEP * b))
            reg_rdata = pend_vec[b*BANK_W +: BANK_W];
      end
   end

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
   parameter int NUM_SRC   = 96,
   parameter int SR_CYCLES = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               irq_out,
   input logic [6:0]         act_num,
   input logic               ack_wr,
   input logic               clear_all,
   input logic               sr_busy,
   input logic               win_valid,
   input logic [6:0]         win_num,
   input logic [NUM_SRC-1:0] src_vec,
   input logic [NUM_SRC-1:0] mask_vec
);

   logic [15:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       busy_cnt <= '0;
      else if (sr_busy) busy_cnt <= busy_cnt + 1'b1;
      else              busy_cnt <= '0;
   end

   // R4: the winner is always an asserted, unmasked line
   assert_win_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (src_vec[win_num] && !mask_vec[win_num]));

   // R5: a latched number stays put until an acknowledge or soft reset
   assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && !ack_wr && !clear_all) |=> (irq_out && $stable(act_num)));

   // R5: with nothing latched, a winner is captured at the next edge
   assert_latch_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_out && win_valid && !ack_wr && !clear_all) |=> (irq_out && act_num == $past(win_num)));

   // R6: an acknowledge drops the request for a cycle
   assert_ack_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && ack_wr) |=> !irq_out);

   // R1: soft reset completion restores the masked state
   assert_clear_masks_R1: assert property (@(posedge clk) disable iff (!rst_n)
      clear_all |=> ((&mask_vec) && !irq_out));

   // R8: soft reset busy window has the configured length
   assert_sr_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sr_busy) |-> (busy_cnt == 16'(SR_CYCLES)));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .SR_CYCLES(SR_CYCLES)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_out   (irq_out),
   .act_num   (act_num),
   .ack_wr    (ack_wr),
   .clear_all (clear_all),
   .sr_busy   (sr_busy),
   .win_valid (win_valid),
   .win_num   (win_num),
   .src_vec   (irq_src),
   .mask_vec  (mask_vec)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;

   localparam int NB  = 3;
   localparam int NS  = NB * 32;
   localparam int SRC = 4;

   localparam int unsigned A_REV = 'h000, A_CFG = 'h010, A_STAT = 'h014, A_SORT = 'h040;
   localparam int unsigned A_ACK = 'h048, A_PROT = 'h04C, A_IDLE = 'h050, A_THR = 'h068;
   localparam int unsigned A_MSK = 'h084, A_MCL = 'h088, A_MST = 'h08C, A_PND = 'h098;
   localparam int unsigned A_LVL = 'h100;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src_m = '0;
   logic [9:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic          reg_we = 1'b0;
   logic [31:0]   reg_rdata;
   logic          irq_out;

   always #2 clk = ~clk;

   prio_irq_ctrl i_prio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_src(src_m), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata), .irq_out(irq_out)
   );

   // ---------------- reference model ----------------
   logic [NS-1:0] mask_m;
   int unsigned   lvl_m [NS];
   int unsigned   thr_m, idle_m, act_n_m;
   bit            cfg_m, prot_m, act_v_m, busy_m;
   int            cnt_m;

   function automatic void model_reset();
      mask_m = '1;
      for (int i = 0; i < NS; i++) lvl_m[i] = 0;
      thr_m = 0; idle_m = 0; cfg_m = 0; prot_m = 0;
      act_v_m = 0; act_n_m = 0; busy_m = 0; cnt_m = 0;
   endfunction

   function automatic int winner_m();
      int best = -1;
      for (int i = 0; i < NS; i++)
         if (src_m[i] && !mask_m[i] && (thr_m == 255 || lvl_m[i] < thr_m))
            if (best < 0 || lvl_m[i] < lvl_m[best]) best = i;
      return best;
   endfunction

   // one clock edge; returns 1 when the soft reset completes there
   function automatic bit edge_m(input bit ack);
      int w;
      if (busy_m) begin
         if (cnt_m == SRC - 1) begin
            model_reset();
            return 1;
         end
         cnt_m++;
      end
      w = winner_m();
      if (ack) begin
         act_v_m = 0; act_n_m = 0;
      end else if (!act_v_m && w >= 0) begin
         act_v_m = 1; act_n_m = w;
      end
      return 0;
   endfunction

   function automatic void write_m(input int unsigned a, input logic [31:0] d);
      if (a == A_CFG) begin
         cfg_m = d[0];
         if (d[1] && !busy_m) begin busy_m = 1; cnt_m = 0; end
      end
      if (a == A_PROT) prot_m = d[0];
      if (a == A_IDLE) idle_m = d[1:0];
      if (a == A_THR)  thr_m  = d[7:0];
      for (int b = 0; b < NB; b++) begin
         if (a == A_MSK + 32*b) mask_m[b*32 +: 32] = d;
         if (a == A_MCL + 32*b) mask_m[b*32 +: 32] = mask_m[b*32 +: 32] & ~d;
         if (a == A_MST + 32*b) mask_m[b*32 +: 32] = mask_m[b*32 +: 32] | d;
      end
      if (a >= A_LVL && a < A_LVL + 4*NS && a % 4 == 0) lvl_m[(a - A_LVL) / 4] = d[7:2];
   endfunction

   function automatic logic [31:0] read_m(input int unsigned a);
      logic [31:0] r = '0;
      if (a == A_REV)  r = 32'h21;
      if (a == A_CFG)  r = {30'b0, busy_m, cfg_m};
      if (a == A_STAT) r = {31'b0, !busy_m};
      if (a == A_SORT) r = act_n_m;
      if (a == A_PROT) r = {31'b0, prot_m};
      if (a == A_IDLE) r = idle_m;
      if (a == A_THR)  r = thr_m;
      for (int b = 0; b < NB; b++) begin
         if (a == A_MSK + 32*b) r = mask_m[b*32 +: 32];
         if (a == A_PND + 32*b) r = src_m[b*32 +: 32] & ~mask_m[b*32 +: 32];
      end
      if (a >= A_LVL && a < A_LVL + 4*NS && a % 4 == 0) r = lvl_m[(a - A_LVL) / 4] << 2;
      return r;
   endfunction

   // ---------------- scoreboard ----------------
   typedef struct {
      bit          is_irq;
      logic [9:0]  addr;
      logic [31:0] exp;
      string       req;
   } item_t;

   item_t exp_q[$];
   int checks = 0;
   int errors = 0;
   bit done = 0;

   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (exp_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = exp_q.pop_front();
            act = it.is_irq ? {31'b0, irq_out} : reg_rdata;
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s %s addr=%h actual=%h expected=%h", it.req,
                        it.is_irq ? "irq_out" : "reg", it.addr, act, it.exp);
            end
         end
      end
   end

   // ---------------- driver tasks ----------------
   task automatic step();
      void'(edge_m(0));
      @(negedge clk);
   endtask

   task automatic wr(input int unsigned a, input logic [31:0] d);
      bit c;
      reg_addr  = a[9:0];
      reg_wdata = d;
      reg_we    = 1'b1;
      c = edge_m(a == A_ACK && d[0]);
      if (!c) write_m(a, d);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int unsigned a, input string req);
      exp_q.push_back('{0, a[9:0], read_m(a), req});
      reg_addr = a[9:0];
      step();
   endtask

   task automatic chk_act(input string req);
      exp_q.push_back('{1, 10'h0, {31'b0, act_v_m}, req});
      rd(A_SORT, req);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 and R1: reset state
      rd(A_REV, "R10");
      for (int b = 0; b < NB; b++) rd(A_MSK + 32*b, "R1");
      chk_act("R1");
      rd(A_THR, "R1");
      rd(A_STAT, "R1");
      rd(A_LVL + 4*5, "R1");
      src_m = {32'hA5A5_0F0F, 32'hFFFF_FFFF, 32'h1234_8001};
      for (int b = 0; b < NB; b++) rd(A_PND + 32*b, "R3");

      // R2: aliases
      wr(A_MCL, 32'h0000_00F0);  rd(A_MSK, "R2");
      wr(A_MST, 32'h0000_0030);  rd(A_MSK, "R2");
      wr(A_MSK + 32, 32'h1234_5678); rd(A_MSK + 32, "R2");
      rd(A_PND + 32, "R3");
      rd(A_PND, "R3");
      chk_act("R4");                        // threshold 0 blocks all

      // R9: read-back
      wr(A_LVL + 4*7, 32'hFFFF_FFFF); rd(A_LVL + 4*7, "R9");
      wr(A_THR, 32'h0000_01AB);       rd(A_THR, "R9");
      wr(A_IDLE, 32'h7);              rd(A_IDLE, "R9");
      wr(A_PROT, 32'h3);              rd(A_PROT, "R9");
      wr(A_CFG, 32'h1);               rd(A_CFG, "R9");

      for (int b = 0; b < NB; b++) wr(A_MSK + 32*b, '1);
      src_m = '0;

      // R5: latch and freeze
      wr(A_THR, 32'hFF);
      wr(A_LVL + 4*5, 8 << 2);
      wr(A_MCL, (1 << 5) | (1 << 3));
      src_m[5] = 1'b1;
      step(); chk_act("R5");
      src_m[3] = 1'b1;
      step(); chk_act("R5");

      // R6: acknowledge
      wr(A_ACK, 0); chk_act("R6");
      wr(A_ACK, 1); chk_act("R6");
      chk_act("R4");

      // R7: masked / deasserted while latched
      wr(A_MST, 1 << 3); chk_act("R7");
      wr(A_ACK, 1); step(); chk_act("R7");
      src_m[5] = 1'b0;
      step(); chk_act("R7");
      wr(A_ACK, 1); step(); chk_act("R7");

      // R4: ties, threshold and top bank
      wr(A_LVL + 4*9, 4 << 2);
      wr(A_LVL + 4*7, 4 << 2);
      wr(A_MCL, (1 << 7) | (1 << 9));
      src_m[9] = 1'b1; src_m[7] = 1'b1;
      step(); chk_act("R4");
      wr(A_THR, 4); wr(A_ACK, 1); step(); chk_act("R4");
      wr(A_THR, 5); step(); chk_act("R4");
      wr(A_LVL + 4*95, 0);
      wr(A_MCL + 64, 32'h8000_0000);
      src_m[95] = 1'b1;
      wr(A_ACK, 1); step(); chk_act("R4");
      rd(A_PND + 64, "R3");

      // random phase
      wr(A_THR, 32'hFF);
      for (int n = 0; n < 400; n++) begin
         int unsigned bk;
         bk = $urandom_range(0, NB - 1);
         case ($urandom_range(0, 7))
            0: begin
                  src_m = {32'($urandom & $urandom), 32'($urandom & $urandom),
                           32'($urandom & $urandom)};
                  step();
               end
            1: wr(A_MCL + 32*bk, $urandom & $urandom);
            2: wr(A_MST + 32*bk, $urandom & $urandom & $urandom);
            3: wr(A_ACK, 1);
            4: wr(A_LVL + 4*$urandom_range(0, NS - 1), $urandom_range(0, 3) << 2);
            5: wr(A_THR, ($urandom_range(0, 3) == 0) ? $urandom_range(1, 4) : 32'hFF);
            6: wr(A_ACK, 0);
            default: step();
         endcase
         chk_act("R5");
         rd(A_PND + 32*$urandom_range(0, NB - 1), "R3");
      end

      // R8: soft reset
      wr(A_CFG, 32'h3);
      rd(A_CFG, "R8");
      for (int k = 0; k < 5; k++) rd(A_STAT, "R8");
      rd(A_CFG, "R8");
      for (int b = 0; b < NB; b++) rd(A_MSK + 32*b, "R8");
      rd(A_THR, "R8");
      rd(A_LVL + 4*95, "R8");
      chk_act("R8");

      step(); step();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule